// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes the length-setting part of a vector-configuration instruction. Each request carries the index and value of the source register, the index of the destination register, and the maximum vector length that the new element width and grouping allow. The unit keeps the active vector length and the maximum length of the last accepted configuration as internal state. It picks an application vector length (AVL) from the source, works out the new vector length, and decides whether the destination register is written back.

The choice depends on the register indices as well as on the register value. A non-zero source index uses the register value as an unsigned AVL. A zero source index with a non-zero destination requests the largest possible length. Zero in both indices keeps the current length. That last form is legal only when the maximum length does not change, and the unit reports a violation through an illegal flag. Results appear one clock edge after the request. The register write enable, the index and the data are presented in the same cycle as the new length.

Top module: `vcfg_unit`

## Requirements
- R1: While reset is asserted, and before any request, vl_o is 0 and resp_valid_o, rd_we_o and illegal_o are 0. The stored maximum length resets to 0.
- R2: With a non-zero rs1_idx_i, the AVL is rs1_val_i read as unsigned. The new vl_o is the smaller of that AVL and vlmax_i.
- R3: With a non-zero rs1_idx_i, the new length is written back: rd_we_o is 1 when rd_idx_i is non-zero, rd_idx_o equals rd_idx_i and rd_wdata_o holds the new length zero-extended. With rd_idx_i of 0, rd_we_o stays 0 and vl_o is still updated.
- R4: With rs1_idx_i of 0 and a non-zero rd_idx_i, vl_o becomes vlmax_i whatever rs1_val_i holds. rd_we_o is 1 and rd_wdata_o equals vlmax_i.
- R5: With both indices 0 and vlmax_i equal to the stored maximum, the request is legal. vl_o keeps its value, rd_we_o is 0 and illegal_o is 0.
- R6: With both indices 0 and vlmax_i different from the stored maximum, illegal_o is 1 and rd_we_o is 0. Neither vl_o nor the stored maximum changes.
- R7: resp_valid_o is 1 in exactly the cycle after a cycle with req_valid_i high. Without a request, resp_valid_o is 0, and vl_o and illegal_o do not signal a new result.
- R8: AVL values above vlmax_i, including all-ones, clamp to vlmax_i. An AVL of 0 gives a length of 0. An AVL equal to vlmax_i gives vlmax_i.
- R9: Every legal request stores its vlmax_i as the new maximum, and later keep-length requests are judged against that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe for one cycle |
| rs1_idx_i | input | REG_IDX_W | Source register index |
| rd_idx_i | input | REG_IDX_W | Destination register index |
| rs1_val_i | input | XLEN | Source register value |
| vlmax_i | input | VL_W | Maximum length of the requested configuration |
| resp_valid_o | output | 1 | Result valid, one cycle after the request |
| vl_o | output | VL_W | Active vector length |
| rd_we_o | output | 1 | Destination register write enable |
| rd_idx_o | output | REG_IDX_W | Destination register index for the write |
| rd_wdata_o | output | XLEN | Write data, the new length zero-extended |
| illegal_o | output | 1 | Keep-length form that would change the maximum |

## Verification
The bench targets the cases where the index, not the value, decides the outcome. It uses a zero source index with a non-zero value. A design that read the value there would produce a clamped length instead of vlmax_i. It also checks the zero destination with a non-zero source, where a careless decoder would write register zero or skip the length update. Keep-length requests are issued right after reset, after a legal reconfiguration and after an illegal one. A design that failed to update the stored maximum, or that updated it on an illegal request, would then flag the wrong request. The clamping boundaries (zero, exact, all-ones) catch a compare that is off by one or truncated to the length width.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  typedef enum logic [1:0] {
    AVL_FROM_REG  = 2'd0,
    AVL_FROM_MAX  = 2'd1,
    AVL_FROM_KEEP = 2'd2
  } avl_src_e;

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic [REG_IDX_W-1:0] rs1_idx_i,
  input  logic [REG_IDX_W-1:0] rd_idx_i,
  output avl_src_e             avl_src_o,
  output logic                 wb_en_o
);

  logic rs1_zero, rd_zero;

  assign rs1_zero = (rs1_idx_i == '0);
  assign rd_zero  = (rd_idx_i == '0);

  always_comb begin
    if (!rs1_zero)     avl_src_o = AVL_FROM_REG;
    else if (!rd_zero) avl_src_o = AVL_FROM_MAX;
    else               avl_src_o = AVL_FROM_KEEP;
  end

  // writes to register zero are dropped here rather than downstream
  assign wb_en_o = !rd_zero;

endmodule

// File: rtl/vcfg_vl_calc.sv
module vcfg_vl_calc
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VL_W = 9
) (
  input  avl_src_e          avl_src_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  input  logic [VL_W-1:0]   cur_vl_i,
  input  logic [VL_W-1:0]   vlmax_i,
  output logic [VL_W-1:0]   new_vl_o
);

  logic [XLEN-1:0] avl;
  logic            avl_above;

  always_comb begin
    unique case (avl_src_i)
      AVL_FROM_REG:  avl = rs1_val_i;
      AVL_FROM_MAX:  avl = '1;
      default:       avl = XLEN'(cur_vl_i);
    endcase
  end

  generate
    if (XLEN > VL_W) begin : g_wide
      logic hi_set;
      assign hi_set    = |avl[XLEN-1:VL_W];
      assign avl_above = hi_set || (avl[VL_W-1:0] > vlmax_i);
    end else begin : g_narrow
      assign avl_above = (avl[VL_W-1:0] > vlmax_i);
    end
  endgenerate

  assign new_vl_o = avl_above ? vlmax_i : avl[VL_W-1:0];

endmodule

// File: rtl/vcfg_state.sv
module vcfg_state #(
  parameter int REG_IDX_W = 5,
  parameter int VL_W      = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 illegal_i,
  input  logic                 wb_en_i,
  input  logic [REG_IDX_W-1:0] rd_idx_i,
  input  logic [VL_W-1:0]      new_vl_i,
  input  logic [VL_W-1:0]      vlmax_i,
  output logic [VL_W-1:0]      vl_o,
  output logic [VL_W-1:0]      vlmax_o,
  output logic                 resp_valid_o,
  output logic                 rd_we_o,
  output logic [REG_IDX_W-1:0] rd_idx_o,
  output logic                 illegal_o
);

  logic                 accept;

  assign accept = req_valid_i && !illegal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_o         <= '0;
      vlmax_o      <= '0;
      resp_valid_o <= 1'b0;
      rd_we_o      <= 1'b0;
      rd_idx_o     <= '0;
      illegal_o    <= 1'b0;
    end else begin
      resp_valid_o <= req_valid_i;
      illegal_o    <= req_valid_i && illegal_i;
      rd_we_o      <= accept && wb_en_i;
      if (req_valid_i) rd_idx_o <= rd_idx_i;
      if (accept) begin
        vl_o    <= new_vl_i;
        vlmax_o <= vlmax_i;
      end
    end
  end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int REG_IDX_W   = 5,
  parameter int VLMAX_LIMIT = 256,
  localparam int VL_W       = $clog2(VLMAX_LIMIT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [REG_IDX_W-1:0] rs1_idx_i,
  input  logic [REG_IDX_W-1:0] rd_idx_i,
  input  logic [XLEN-1:0]      rs1_val_i,
  input  logic [VL_W-1:0]      vlmax_i,
  output logic                 resp_valid_o,
  output logic [VL_W-1:0]      vl_o,
  output logic                 rd_we_o,
  output logic [REG_IDX_W-1:0] rd_idx_o,
  output logic [XLEN-1:0]      rd_wdata_o,
  output logic                 illegal_o
);

  avl_src_e        avl_src;
  logic            wb_en;
  logic [VL_W-1:0] new_vl;
  logic [VL_W-1:0] vl_q;
  logic [VL_W-1:0] vlmax_q;
  logic            keep_bad;

  vcfg_decode #(.REG_IDX_W(REG_IDX_W)) u_decode (
    .rs1_idx_i (rs1_idx_i),
    .rd_idx_i  (rd_idx_i),
    .avl_src_o (avl_src),
    .wb_en_o   (wb_en)
  );

  vcfg_vl_calc #(.XLEN(XLEN), .VL_W(VL_W)) u_calc (
    .avl_src_i (avl_src),
    .rs1_val_i (rs1_val_i),
    .cur_vl_i  (vl_q),
    .vlmax_i   (vlmax_i),
    .new_vl_o  (new_vl)
  );

  // keep-length form may not alter the maximum
  assign keep_bad = (avl_src == AVL_FROM_KEEP) && (vlmax_i != vlmax_q);

  vcfg_state #(.REG_IDX_W(REG_IDX_W), .VL_W(VL_W)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .illegal_i    (keep_bad),
    .wb_en_i      (wb_en),
    .rd_idx_i     (rd_idx_i),
    .new_vl_i     (new_vl),
    .vlmax_i      (vlmax_i),
    .vl_o         (vl_q),
    .vlmax_o      (vlmax_q),
    .resp_valid_o (resp_valid_o),
    .rd_we_o      (rd_we_o),
    .rd_idx_o     (rd_idx_o),
    .illegal_o    (illegal_o)
  );

  assign vl_o       = vl_q;
  assign rd_wdata_o = XLEN'(vl_q);

endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int XLEN        = 32,
  parameter int REG_IDX_W   = 5,
  parameter int VLMAX_LIMIT = 256,
  localparam int VL_W       = $clog2(VLMAX_LIMIT + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic [REG_IDX_W-1:0] rs1_idx_i,
  input logic [REG_IDX_W-1:0] rd_idx_i,
  input logic [XLEN-1:0]      rs1_val_i,
  input logic [VL_W-1:0]      vlmax_i,
  input logic                 resp_valid_o,
  input logic [VL_W-1:0]      vl_o,
  input logic                 rd_we_o,
  input logic [REG_IDX_W-1:0] rd_idx_o,
  input logic                 illegal_o
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!resp_valid_o && !rd_we_o && !illegal_o && vl_o == '0)
        else $error("p_reset_quiet_r1");
    end
  end

  p_rs1_fits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rs1_idx_i != '0 && rs1_val_i <= XLEN'(vlmax_i))
      |=> (vl_o == $past(rs1_val_i[VL_W-1:0])));

  p_we_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rd_idx_o != '0 && rd_idx_o == $past(rd_idx_i)));

  p_max_form_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rs1_idx_i == '0 && rd_idx_i != '0)
      |=> (vl_o == $past(vlmax_i) && rd_we_o && !illegal_o));

  p_keep_no_we_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rs1_idx_i == '0 && rd_idx_i == '0) |=> (!rd_we_o && $stable(vl_o)));

  p_illegal_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!rd_we_o && vl_o == $past(vl_o)));

  p_resp_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!resp_valid_o && !illegal_o && !rd_we_o && $stable(vl_o)));

  p_clamp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !illegal_o) |-> (vl_o <= $past(vlmax_i)));

endmodule

bind vcfg_unit vcfg_unit_chk #(
  .XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .VLMAX_LIMIT(VLMAX_LIMIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .rs1_idx_i    (rs1_idx_i),
  .rd_idx_i     (rd_idx_i),
  .rs1_val_i    (rs1_val_i),
  .vlmax_i      (vlmax_i),
  .resp_valid_o (resp_valid_o),
  .vl_o         (vl_o),
  .rd_we_o      (rd_we_o),
  .rd_idx_o     (rd_idx_o),
  .illegal_o    (illegal_o)
);

// File: tb/vcfg_unit_bench.sv
`timescale 1ns/1ps
module vcfg_unit_bench;

  localparam int XLEN        = 32;
  localparam int REG_IDX_W   = 5;
  localparam int VLMAX_LIMIT = 256;
  localparam int VL_W        = $clog2(VLMAX_LIMIT + 1);

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 req_valid_i = 1'b0;
  logic [REG_IDX_W-1:0] rs1_idx_i = '0;
  logic [REG_IDX_W-1:0] rd_idx_i = '0;
  logic [XLEN-1:0]      rs1_val_i = '0;
  logic [VL_W-1:0]      vlmax_i = '0;
  logic                 resp_valid_o;
  logic [VL_W-1:0]      vl_o;
  logic                 rd_we_o;
  logic [REG_IDX_W-1:0] rd_idx_o;
  logic [XLEN-1:0]      rd_wdata_o;
  logic                 illegal_o;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_vl    = 0;
  int exp_vlmax = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  vcfg_unit #(.XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .VLMAX_LIMIT(VLMAX_LIMIT)) u_vcfg_unit (
    .clk_i, .rst_ni, .req_valid_i, .rs1_idx_i, .rd_idx_i, .rs1_val_i, .vlmax_i,
    .resp_valid_o, .vl_o, .rd_we_o, .rd_idx_o, .rd_wdata_o, .illegal_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one request cycle, then sample the registered response at the next negedge
  task automatic issue(input int rs1, input int rd, input logic [XLEN-1:0] val, input int vmax);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    rs1_idx_i   = REG_IDX_W'(rs1);
    rd_idx_i    = REG_IDX_W'(rd);
    rs1_val_i   = val;
    vlmax_i     = VL_W'(vmax);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    rs1_val_i   = 32'hDEAD_BEEF;
  endtask

  task automatic t_reset();
    chk(vl_o == 0, "R1 vl", vl_o, 0);
    chk(!resp_valid_o, "R1 valid", resp_valid_o, 0);
    chk(!rd_we_o && !illegal_o, "R1 we/illegal", {rd_we_o, illegal_o}, 0);
  endtask

  task automatic t_reg_form(input int rs1, input int rd, input logic [XLEN-1:0] val, input int vmax,
                            input string tag);
    longint avl = longint'(val);
    exp_vl    = (avl > vmax) ? vmax : int'(avl);
    exp_vlmax = vmax;
    issue(rs1, rd, val, vmax);
    chk(resp_valid_o, {tag, " valid R7"}, resp_valid_o, 1);
    chk(vl_o == VL_W'(exp_vl), {tag, " vl"}, vl_o, exp_vl);
    chk(rd_we_o == (rd != 0), {tag, " we R3"}, rd_we_o, rd != 0);
    if (rd != 0) begin
      chk(rd_idx_o == REG_IDX_W'(rd), {tag, " idx R3"}, rd_idx_o, rd);
      chk(rd_wdata_o == XLEN'(exp_vl), {tag, " data R3"}, rd_wdata_o, exp_vl);
    end
    chk(!illegal_o, {tag, " illegal"}, illegal_o, 0);
  endtask

  task automatic t_max_form(input int rd, input int vmax);
    exp_vl    = vmax;
    exp_vlmax = vmax;
    issue(0, rd, 32'h0000_0003, vmax);
    chk(vl_o == VL_W'(vmax), "R4 vl", vl_o, vmax);
    chk(rd_we_o, "R4 we", rd_we_o, 1);
    chk(rd_wdata_o == XLEN'(vmax), "R4 data", rd_wdata_o, vmax);
  endtask

  task automatic t_keep_form(input int vmax, input string tag);
    bit bad = (vmax != exp_vlmax);
    issue(0, 0, 32'h0000_0001, vmax);
    chk(illegal_o == bad, {tag, " illegal"}, illegal_o, bad);
    chk(vl_o == VL_W'(exp_vl), {tag, " vl kept"}, vl_o, exp_vl);
    chk(!rd_we_o, {tag, " no write"}, rd_we_o, 0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(!resp_valid_o && !illegal_o, "R7 idle valid", resp_valid_o, 0);
      chk(vl_o == VL_W'(exp_vl), "R7 idle vl", vl_o, exp_vl);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_keep_form(16, "R6 after reset");
    t_keep_form(0, "R5 after reset");
    t_reg_form(5, 7, 32'd10, 64, "R2 small");
    t_reg_form(5, 7, 32'd1000, 64, "R8 above");
    t_reg_form(9, 1, 32'hFFFF_FFFF, 256, "R8 all-ones");
    t_reg_form(9, 2, 32'd0, 256, "R8 zero");
    t_reg_form(3, 4, 32'd128, 128, "R8 exact");
    t_reg_form(6, 0, 32'd20, 100, "R3 rd zero");
    t_max_form(3, 32);
    t_reg_form(2, 5, 32'd10, 32, "R2 reset vl");
    t_keep_form(32, "R5 legal");
    t_keep_form(64, "R6 changes");
    t_keep_form(32, "R6 max unchanged");
    t_reg_form(8, 8, 32'd7, 128, "R9 reconfig");
    t_keep_form(128, "R9 new max");
    t_idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule